// File: doc/BRIEF.md
# Host Controller Error Halt Unit

This block holds the run/stop control, the status flags and the interrupt line of a bus-mastering USB host controller. It watches the system bus for fatal faults. Any master abort, target abort or data-phase parity error ends the controller's run, whatever kind of cycle was in progress. So does a structure fetch that would run past the end of a 4 KB page. After such a fault the controller stops, flags the fault, records the tag of the failing cycle and interrupts at once.

Ordinary interrupt sources are handled differently. Transfer completion and port change are gathered in status bits and signalled only when a programmable microframe threshold counter expires. A system-error interrupt bypasses that counter.

Once a fault has occurred, the controller cannot be restarted by setting run/stop. Software must first issue a command reset. The reset occupies a fixed number of cycles and returns every register to its default.

Top module: `usbh_err_halt`

## Requirements
- R1: A pulse on `err_mabort`, `err_tabort` or `err_parity`, for any `err_tag` value, is fatal. After the next clock edge `sts_sys_err` is 1 and `fail_tag` holds the `err_tag` value of that cycle.
- R2: A `fetch_req` is fatal when the low 12 bits of `fetch_addr` plus `fetch_len` exceed 4096. A fetch that ends exactly at 4096, or has length 0, is not fatal.
- R3: On the edge after a fatal error, `run` is 0 and `halted` is 1, even with `bus_busy` high.
- R4: When interrupt-enable bit 2 (system error) is set, `irq` is 1 on the edge after a fatal error, whatever the state of the threshold counter.
- R5: After a fatal error, a command write with `cmd_run`=1 and `cmd_reset`=0 leaves `run` at 0. This holds even after `sts_sys_err` has been cleared, and lasts until a command reset.
- R6: A command write with `cmd_reset`=1 raises `rst_busy` for 4 cycles. During that time `run`=0, `halted`=1 and the status bits are 0, and both errors and writes are ignored. Afterwards a write with `cmd_run`=1 sets `run`.
- R7: Status bits are cleared by writing 1 to their position on `sts_clr`: bit 0 transfer, bit 1 port change, bit 2 system error. `irq` falls when no enabled source remains pending.
- R8: After `rst_n` is released: `run`=0, `halted`=1, every status bit is 0, `irq`=0, `rst_busy`=0, the interrupt enables are 0 and the threshold code is 3.
- R9: `halted` falls one edge after `run` is set. It rises one edge after `run` is 0 with `bus_busy` low, and stays 0 while `bus_busy` is high.
- R10: Normal interrupts have enable bit 0 (transfer) and enable bit 1 (port change). They raise `irq` only when the threshold counter expires. The counter expires after 2^code `uframe_tick` pulses while running. Codes above 6 count as 6, and every command write restarts the counter. A source whose enable is 0 never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_run | input | 1 | Run/stop value written |
| cmd_reset | input | 1 | Command reset request |
| cmd_thr | input | 3 | Threshold code written (2^code microframes) |
| ien_we | input | 1 | Interrupt-enable write strobe |
| ien_data | input | 3 | Enables: bit0 transfer, bit1 port, bit2 system error |
| sts_clr_we | input | 1 | Status write-1-to-clear strobe |
| sts_clr | input | 3 | Clear mask, same bit order as the enables |
| uframe_tick | input | 1 | Microframe strobe |
| ev_xfer | input | 1 | Transfer-complete event |
| ev_port | input | 1 | Port-change event |
| bus_busy | input | 1 | A bus transaction is in flight |
| err_mabort | input | 1 | Master abort strobe |
| err_tabort | input | 1 | Target abort strobe |
| err_parity | input | 1 | Data-phase parity error strobe |
| err_tag | input | 4 | Cycle type of the current bus cycle |
| fetch_req | input | 1 | Structure fetch request |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_len | input | 13 | Fetch length in bytes |
| run | output | 1 | Run/stop state |
| halted | output | 1 | Halted status |
| sts_xfer | output | 1 | Transfer-complete status |
| sts_port | output | 1 | Port-change status |
| sts_sys_err | output | 1 | System-error status |
| irq | output | 1 | Interrupt output |
| rst_busy | output | 1 | Command reset in progress |
| fail_tag | output | 4 | Cycle tag of the first fatal error |

## Verification
The lock-out after a fault is the hardest state to reach from the ports. It needs a running controller, a fault, a cleared system-error bit and then another run request. The bench builds that sequence step by step and shows that only the command reset brings `run` back.

The page-boundary rule is exercised from a table of offset/length pairs on both sides of 4096. Each pair starts from a freshly reset, running controller.

The threshold path needs a pending event and an exact number of microframe ticks. The bench counts one tick short of expiry and then exactly to expiry.

// File: rtl/usbh_err_halt.sv
module usbh_err_halt #(
  parameter int ADDR_W      = 32,
  parameter int PAGE_BITS   = 12,
  parameter int TAG_W       = 4,
  parameter int THR_CODE_W  = 3,
  parameter int THR_LOG_MAX = 6,
  parameter int THR_DEFAULT = 3,
  parameter int RST_CYCLES  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_we,
  input  logic                  cmd_run,
  input  logic                  cmd_reset,
  input  logic [THR_CODE_W-1:0] cmd_thr,
  input  logic                  ien_we,
  input  logic [2:0]            ien_data,
  input  logic                  sts_clr_we,
  input  logic [2:0]            sts_clr,
  input  logic                  uframe_tick,
  input  logic                  ev_xfer,
  input  logic                  ev_port,
  input  logic                  bus_busy,
  input  logic                  err_mabort,
  input  logic                  err_tabort,
  input  logic                  err_parity,
  input  logic [TAG_W-1:0]      err_tag,
  input  logic                  fetch_req,
  input  logic [ADDR_W-1:0]     fetch_addr,
  input  logic [PAGE_BITS:0]    fetch_len,
  output logic                  run,
  output logic                  halted,
  output logic                  sts_xfer,
  output logic                  sts_port,
  output logic                  sts_sys_err,
  output logic                  irq,
  output logic                  rst_busy,
  output logic [TAG_W-1:0]      fail_tag
);
  localparam int CNT_W = THR_LOG_MAX;
  localparam int RC_W  = $clog2(RST_CYCLES + 1);
  localparam logic [PAGE_BITS+1:0] PAGE_SIZE = (PAGE_BITS+2)'(1) << PAGE_BITS;

  logic                  dead;
  logic [2:0]            ien_q;
  logic [THR_CODE_W-1:0] thr_q;
  logic [CNT_W-1:0]      cnt;
  logic                  irq_norm_q;
  logic [RC_W-1:0]       rst_cnt;

  logic [PAGE_BITS+1:0]  fetch_end;
  logic                  page_cross, fatal, start_rst, norm_pend, expire;
  logic [THR_CODE_W-1:0] code_c;
  logic [CNT_W-1:0]      cnt_last;
  logic [2:0]            clr;

  assign fetch_end  = {2'b00, fetch_addr[PAGE_BITS-1:0]} + {1'b0, fetch_len};
  assign page_cross = fetch_req && (fetch_end > PAGE_SIZE);
  assign fatal      = err_mabort | err_tabort | err_parity | page_cross;
  assign rst_busy   = (rst_cnt != '0);
  assign start_rst  = cmd_we && cmd_reset && !rst_busy;
  assign code_c     = (thr_q > THR_CODE_W'(THR_LOG_MAX)) ? THR_CODE_W'(THR_LOG_MAX) : thr_q;
  assign cnt_last   = {CNT_W{1'b1}} >> (THR_CODE_W'(THR_LOG_MAX) - code_c);
  assign expire     = run && uframe_tick && (cnt == cnt_last);
  assign norm_pend  = (sts_xfer & ien_q[0]) | (sts_port & ien_q[1]);
  assign irq        = (sts_sys_err & ien_q[2]) | (irq_norm_q & norm_pend);
  assign clr        = sts_clr_we ? sts_clr : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; halted <= 1'b1; dead <= 1'b0;
      sts_xfer <= 1'b0; sts_port <= 1'b0; sts_sys_err <= 1'b0;
      ien_q <= '0; thr_q <= THR_CODE_W'(THR_DEFAULT); cnt <= '0;
      irq_norm_q <= 1'b0; rst_cnt <= '0; fail_tag <= '0;
    end else if (start_rst || rst_busy) begin
      run <= 1'b0; halted <= 1'b1; dead <= 1'b0;
      sts_xfer <= 1'b0; sts_port <= 1'b0; sts_sys_err <= 1'b0;
      ien_q <= '0; thr_q <= THR_CODE_W'(THR_DEFAULT); cnt <= '0;
      irq_norm_q <= 1'b0; fail_tag <= '0;
      rst_cnt <= start_rst ? RC_W'(RST_CYCLES) : rst_cnt - 1'b1;
    end else begin
      if (fatal)       run <= 1'b0;
      else if (cmd_we) run <= cmd_run & ~dead;

      if (fatal)          halted <= 1'b1;
      else if (run)       halted <= 1'b0;
      else if (!bus_busy) halted <= 1'b1;

      dead <= dead | fatal;
      if (fatal && !dead) fail_tag <= err_tag;

      if (cmd_we) begin
        thr_q <= cmd_thr;
        cnt   <= '0;
      end else if (run && uframe_tick) begin
        cnt <= expire ? '0 : cnt + 1'b1;
      end

      if (ien_we) ien_q <= ien_data;

      sts_xfer    <= (sts_xfer    & ~clr[0]) | ev_xfer;
      sts_port    <= (sts_port    & ~clr[1]) | ev_port;
      sts_sys_err <= (sts_sys_err & ~clr[2]) | fatal;

      if (expire && norm_pend) irq_norm_q <= 1'b1;
      else if (!norm_pend)     irq_norm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/usbh_err_halt_chk.sv
module usbh_err_halt_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_we,
  input logic                 cmd_reset,
  input logic                 ien_we,
  input logic                 err_mabort,
  input logic                 err_tabort,
  input logic                 err_parity,
  input logic                 fetch_req,
  input logic [ADDR_W-1:0]    fetch_addr,
  input logic [PAGE_BITS:0]   fetch_len,
  input logic                 run,
  input logic                 halted,
  input logic                 sts_sys_err,
  input logic                 irq,
  input logic                 rst_busy,
  input logic                 dead,
  input logic                 ien_se
);
  logic any_err, quiet, over_page;
  assign any_err   = err_mabort | err_tabort | err_parity;
  assign quiet     = !rst_busy && !(cmd_we && cmd_reset);
  assign over_page = fetch_req &&
    (({2'b00, fetch_addr[PAGE_BITS-1:0]} + {1'b0, fetch_len}) > ((PAGE_BITS+2)'(1) << PAGE_BITS));

  p_bus_err_fatal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    any_err && quiet |=> sts_sys_err);
  p_page_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
    over_page && quiet |=> sts_sys_err);
  p_err_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_err && quiet |=> !run && halted);
  p_irq_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_err && ien_se && quiet && !ien_we |=> irq);
  p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dead && quiet |=> !run);
  p_reset_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> !run && halted && !sts_sys_err);
  p_run_clears_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run && !any_err && !fetch_req && !cmd_we && !rst_busy |=> !halted);
endmodule

bind usbh_err_halt usbh_err_halt_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_reset(cmd_reset), .ien_we(ien_we),
  .err_mabort(err_mabort), .err_tabort(err_tabort), .err_parity(err_parity),
  .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_len(fetch_len),
  .run(run), .halted(halted), .sts_sys_err(sts_sys_err), .irq(irq),
  .rst_busy(rst_busy), .dead(dead), .ien_se(ien_q[2]));

// File: tb/usbh_err_halt_tb_top.sv
module usbh_err_halt_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, cmd_run = 0, cmd_reset = 0;
  logic [2:0] cmd_thr = 3'd3;
  logic ien_we = 0, sts_clr_we = 0;
  logic [2:0] ien_data = 0, sts_clr = 0;
  logic uframe_tick = 0, ev_xfer = 0, ev_port = 0, bus_busy = 0;
  logic err_mabort = 0, err_tabort = 0, err_parity = 0, fetch_req = 0;
  logic [3:0] err_tag = 0;
  logic [31:0] fetch_addr = 0;
  logic [12:0] fetch_len = 0;
  logic run, halted, sts_xfer, sts_port, sts_sys_err, irq, rst_busy;
  logic [3:0] fail_tag;
  int nchk = 0, nfail = 0, cyc = 0;

  always #4 clk = ~clk;

  usbh_err_halt dut_i (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // {mab, tab, par, freq, tag[3:0], offset[11:0], len[12:0], fatal}
  localparam logic [33:0] VEC [8] = '{
    {4'b1000, 4'd0,  12'h000, 13'd0,    1'b1},
    {4'b0100, 4'd5,  12'h000, 13'd0,    1'b1},
    {4'b0010, 4'd8,  12'h000, 13'd0,    1'b1},
    {4'b0001, 4'd3,  12'hF00, 13'h0100, 1'b0},
    {4'b0001, 4'd6,  12'hF00, 13'h0101, 1'b1},
    {4'b0001, 4'd7,  12'h000, 13'h1000, 1'b0},
    {4'b0001, 4'd9,  12'hFFF, 13'd2,    1'b1},
    {4'b0001, 4'd2,  12'h123, 13'd0,    1'b0}
  };

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic r, input logic rs, input logic [2:0] t);
    cmd_we = 1; cmd_run = r; cmd_reset = rs; cmd_thr = t;
    step();
    cmd_we = 0; cmd_run = 0; cmd_reset = 0;
  endtask

  task automatic wr_ien(input logic [2:0] v);
    ien_we = 1; ien_data = v; step(); ien_we = 0;
  endtask

  task automatic clr_sts(input logic [2:0] v);
    sts_clr_we = 1; sts_clr = v; step(); sts_clr_we = 0; sts_clr = 0;
  endtask

  task automatic sw_reset();
    wr_cmd(0, 1, 0);
    repeat (4) step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      uframe_tick = 1; step(); uframe_tick = 0;
    end
  endtask

  initial begin
    step(); step();
    rst_n = 1;
    step();
    chk("R8 run", run, 0);
    chk("R8 halted", halted, 1);
    chk("R8 status", {sts_sys_err, sts_port, sts_xfer}, 0);
    chk("R8 irq", irq, 0);
    chk("R8 rst_busy", rst_busy, 0);

    // table of fault vectors, each from a fresh running controller
    for (int v = 0; v < 8; v++) begin
      logic [33:0] e;
      logic f;
      e = VEC[v];
      f = e[0];
      sw_reset();
      wr_ien(3'b100);
      wr_cmd(1, 0, 3);
      step();
      chk("R9 halted clears", halted, 0);
      err_mabort = e[33]; err_tabort = e[32]; err_parity = e[31]; fetch_req = e[30];
      err_tag = e[29:26]; fetch_addr = {20'hABCDE, e[25:14]}; fetch_len = e[13:1];
      step();
      err_mabort = 0; err_tabort = 0; err_parity = 0; fetch_req = 0;
      chk(e[30] ? "R2 sys_err" : "R1 sys_err", sts_sys_err, f);
      chk("R3 run", run, !f);
      chk("R3 halted", halted, f);
      chk("R4 irq", irq, f);
      if (f) chk("R1 fail_tag", fail_tag, e[29:26]);
    end

    // R3 with bus busy, then R5 lock-out and R7 clear
    sw_reset();
    wr_ien(3'b100);
    wr_cmd(1, 0, 6);
    step();
    bus_busy = 1;
    err_parity = 1; err_tag = 4'd11; step(); err_parity = 0;
    chk("R3 halted despite bus_busy", halted, 1);
    chk("R3 run", run, 0);
    bus_busy = 0;
    wr_cmd(1, 0, 6);
    chk("R5 run after fault", run, 0);
    chk("R5 halted after fault", halted, 1);
    clr_sts(3'b100);
    chk("R7 sys_err cleared", sts_sys_err, 0);
    chk("R7 irq dropped", irq, 0);
    wr_cmd(1, 0, 6);
    chk("R5 run after clear", run, 0);

    // R6 command reset
    wr_cmd(0, 1, 0);
    chk("R6 busy", rst_busy, 1);
    err_mabort = 1; step(); err_mabort = 0;
    wr_cmd(1, 0, 3);
    step();
    chk("R6 busy still", rst_busy, 1);
    chk("R6 halted during reset", halted, 1);
    step();
    chk("R6 busy done", rst_busy, 0);
    chk("R6 error ignored", sts_sys_err, 0);
    chk("R6 write ignored", run, 0);
    wr_cmd(1, 0, 3);
    chk("R6 run after reset", run, 1);

    // R9 stop waits for the bus
    step();
    bus_busy = 1;
    wr_cmd(0, 0, 3);
    chk("R9 run off", run, 0);
    step();
    chk("R9 halted held by bus", halted, 0);
    bus_busy = 0;
    step();
    chk("R9 halted set", halted, 1);

    // R10 threshold of 4 microframes
    sw_reset();
    wr_ien(3'b011);
    wr_cmd(1, 0, 2);
    ev_xfer = 1; step(); ev_xfer = 0;
    chk("R10 xfer status", sts_xfer, 1);
    ticks(3);
    chk("R10 irq held", irq, 0);
    ticks(1);
    chk("R10 irq at expiry", irq, 1);
    clr_sts(3'b001);
    chk("R7 irq after xfer clear", irq, 0);

    // R10 disabled source never interrupts
    wr_ien(3'b001);
    wr_cmd(1, 0, 0);
    ev_port = 1; step(); ev_port = 0;
    ticks(3);
    chk("R10 port status", sts_port, 1);
    chk("R10 masked port", irq, 0);

    // R10 code 7 clamps to 64 ticks
    clr_sts(3'b010);
    wr_cmd(1, 0, 7);
    ev_xfer = 1; step(); ev_xfer = 0;
    ticks(63);
    chk("R10 clamp before", irq, 0);
    ticks(1);
    chk("R10 clamp expiry", irq, 1);

    // R4 bypass while threshold far from expiry
    wr_ien(3'b101);
    err_tabort = 1; step(); err_tabort = 0;
    chk("R4 irq bypass", irq, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule